// File: doc/BRIEF.md
# Endian-Selectable Width-Down Converter

This block takes 32-bit long-words on a valid/ready input stream and sends each one out as a series of narrower transfers on a valid/ready output stream. A static mode input picks the lane size. In byte mode each long-word becomes four 8-bit transfers. In half-word mode it becomes two 16-bit transfers. The output bus is always 16 bits wide. In byte mode the lane sits in the low eight bits.

The order of the lanes within a long-word is set by an endian choice. The block samples that choice while reset is held and keeps it until the next reset. Big-endian order sends the most significant lane first. Little-endian order sends the least significant lane first. Only one long-word is held at a time. A new one can enter in the same cycle that the last lane of the current word is taken, so a steady stream runs with no idle cycles on the output.

Top module: `endian_width_down`

## Requirements
- R1: With big-endian order latched, the lanes of each long-word leave most significant first, ending with bits [7:0] (byte mode) or bits [15:0] (half-word mode).
- R2: With little-endian order latched, the lanes leave least significant first, starting with bits [7:0] (byte mode) or bits [15:0] (half-word mode).
- R3: The order is sampled from `cfg_big_endian` (1 = big, 0 = little) on every clock edge where `rst_n` is low. Changes to it while `rst_n` is high have no effect on the lane order.
- R4: When `size_half` is 0 (byte mode), each long-word gives exactly four output transfers, and `out_data[15:8]` is zero while `out_valid` is high.
- R5: When `size_half` is 1 (half-word mode), each long-word gives exactly two 16-bit output transfers.
- R6: `in_ready` is high when no long-word is held, or when the last lane is being taken in that cycle (`out_valid` and `out_ready` both high). At any other time it is low.
- R7: When a long-word is accepted in the same cycle that the previous last lane is taken, `out_valid` stays high and the next cycle shows the first lane of the new long-word.
- R8: While `out_valid` is high and `out_ready` is low, `out_data` and `out_valid` hold their values.
- R9: A clock edge with `rst_n` low clears `out_valid` and the lane position. After reset, `in_ready` is high and the next long-word starts from its first lane.
- R10: `out_valid` is high in the cycle after a long-word is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_big_endian | input | 1 | Endian choice, sampled during reset (1 = big) |
| size_half | input | 1 | Lane size: 0 = byte, 1 = half-word; static |
| in_data | input | 32 | Long-word input |
| in_valid | input | 1 | Input word is valid |
| in_ready | output | 1 | Block can accept a long-word this cycle |
| out_data | output | 16 | Current lane; byte lanes are zero-extended |
| out_valid | output | 1 | Lane on `out_data` is valid |
| out_ready | input | 1 | Downstream takes the lane this cycle |

## Verification
The bench runs the same long-words through both lane orders and both lane sizes. An index that is mirrored the wrong way, or a lane count that is wrong for one mode, shows up as lanes out of order or as an extra or missing transfer. It flips `cfg_big_endian` right after every reset release; a latch that kept sampling would then reverse the order partway through the test. It stalls the output to catch lanes that change under back-pressure. It feeds a new word exactly at a last lane, which catches a design that inserts a bubble or drops the new word. It also resets in the middle of a word, which catches a lane counter that is not cleared and so makes the next word start on its second lane.

// File: rtl/wdc_pkg.sv
// Package: shared types for the width-down converter.
// Assumes: used only by the endian_width_down hierarchy.
package wdc_pkg;

    // Lane order within a long-word
    typedef enum logic {
        ORDER_LITTLE = 1'b0,
        ORDER_BIG    = 1'b1
    } lane_order_e;

    // Size of each output lane
    typedef enum logic {
        LANE_BYTE = 1'b0,
        LANE_HALF = 1'b1
    } lane_size_e;

endpackage

// File: rtl/wdc_order_latch.sv
// Module: wdc_order_latch
// Holds the lane order. It takes the configuration value on every edge
// where reset is active, so the value present at reset release is kept.
// Assumes: cfg_big is stable around the reset release edge.
module wdc_order_latch
    import wdc_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_big,
    output lane_order_e order_o
);

    lane_order_e order_q;

    // Sample the order during reset, hold it afterwards
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            order_q <= cfg_big ? ORDER_BIG : ORDER_LITTLE;
        end
    end

    assign order_o = order_q;

endmodule

// File: rtl/wdc_lane_ctrl.sv
// Module: wdc_lane_ctrl
// Tracks whether a long-word is held and which lane is next to go.
// Handles the input and output handshakes, including taking a new word in
// the same cycle that the last lane is taken.
// Assumes: size_i does not change while a word is partly sent.
module wdc_lane_ctrl
    import wdc_pkg::*;
#(
    parameter int BYTE_LANES = 4,
    parameter int HALF_LANES = 2,
    parameter int CNT_W      = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  lane_size_e       size_i,
    input  logic             in_valid,
    output logic             in_ready,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [CNT_W-1:0] lane_cnt_o,
    output logic             load_o
);

    localparam logic [CNT_W-1:0] BYTE_LAST = CNT_W'(BYTE_LANES - 1);
    localparam logic [CNT_W-1:0] HALF_LAST = CNT_W'(HALF_LANES - 1);

    logic             valid_q;
    logic [CNT_W-1:0] cnt_q;
    logic             last_lane;
    logic             take;
    logic             load;

    // Decode the last lane for the current size and the handshake events
    always_comb begin
        last_lane = (size_i == LANE_HALF) ? (cnt_q == HALF_LAST)
                                          : (cnt_q == BYTE_LAST);
        take      = valid_q && out_ready;
        in_ready  = !valid_q || (take && last_lane);
        load      = in_valid && in_ready;
    end

    // Advance the lane position and the valid flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            cnt_q   <= '0;
        end else if (load) begin
            valid_q <= 1'b1;
            cnt_q   <= '0;
        end else if (take) begin
            if (last_lane) begin
                valid_q <= 1'b0;
                cnt_q   <= '0;
            end else begin
                cnt_q   <= cnt_q + 1'b1;
            end
        end
    end

    assign out_valid  = valid_q;
    assign lane_cnt_o = cnt_q;
    assign load_o     = load;

endmodule

// File: rtl/wdc_lane_select.sv
// Module: wdc_lane_select
// Maps the logical lane number onto a physical slice of the held word,
// using the latched order, and zero-extends byte lanes onto the output.
// Assumes: IN_W is a multiple of OUT_W, and OUT_W a multiple of BYTE_W.
module wdc_lane_select
    import wdc_pkg::*;
#(
    parameter int IN_W   = 32,
    parameter int OUT_W  = 16,
    parameter int BYTE_W = 8,
    parameter int CNT_W  = 2
) (
    input  logic [IN_W-1:0]  word_i,
    input  lane_order_e      order_i,
    input  lane_size_e       size_i,
    input  logic [CNT_W-1:0] lane_cnt_i,
    output logic [OUT_W-1:0] data_o
);

    localparam int BYTE_LANES = IN_W / BYTE_W;
    localparam int HALF_LANES = IN_W / OUT_W;
    localparam int HIDX_W     = $clog2(HALF_LANES);
    localparam logic [CNT_W-1:0]  BYTE_LAST = CNT_W'(BYTE_LANES - 1);
    localparam logic [HIDX_W-1:0] HALF_LAST = HIDX_W'(HALF_LANES - 1);

    logic [BYTE_W-1:0] byte_lane [BYTE_LANES];
    logic [OUT_W-1:0]  half_lane [HALF_LANES];
    logic [CNT_W-1:0]  byte_idx;
    logic [HIDX_W-1:0] half_idx;

    // Split the held word into byte slices
    for (genvar g = 0; g < BYTE_LANES; g++) begin : g_byte
        assign byte_lane[g] = word_i[g*BYTE_W +: BYTE_W];
    end

    // Split the held word into half-word slices
    for (genvar g = 0; g < HALF_LANES; g++) begin : g_half
        assign half_lane[g] = word_i[g*OUT_W +: OUT_W];
    end

    // Mirror the lane index for big-endian order
    always_comb begin
        if (order_i == ORDER_BIG) begin
            byte_idx = BYTE_LAST - lane_cnt_i;
            half_idx = HALF_LAST - lane_cnt_i[HIDX_W-1:0];
        end else begin
            byte_idx = lane_cnt_i;
            half_idx = lane_cnt_i[HIDX_W-1:0];
        end
    end

    // Drive the chosen slice, zero-extending byte lanes
    always_comb begin
        data_o = '0;
        if (size_i == LANE_HALF) begin
            data_o = half_lane[half_idx];
        end else begin
            data_o[BYTE_W-1:0] = byte_lane[byte_idx];
        end
    end

endmodule

// File: rtl/endian_width_down.sv
// Module: endian_width_down (top)
// Splits each 32-bit long-word into byte or half-word lanes, in an order
// chosen at reset. It holds one word at a time and accepts the next word
// in the same cycle that the last lane leaves.
// Assumes: size_half is static while a word is held; cfg_big_endian is
// meaningful only while rst_n is low.
module endian_width_down
    import wdc_pkg::*;
#(
    parameter int IN_W   = 32,
    parameter int OUT_W  = 16,
    parameter int BYTE_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_big_endian,
    input  logic             size_half,
    input  logic [IN_W-1:0]  in_data,
    input  logic             in_valid,
    output logic             in_ready,
    output logic [OUT_W-1:0] out_data,
    output logic             out_valid,
    input  logic             out_ready
);

    localparam int BYTE_LANES = IN_W / BYTE_W;
    localparam int HALF_LANES = IN_W / OUT_W;
    localparam int CNT_W      = $clog2(BYTE_LANES);

    lane_order_e      order_q;
    lane_size_e       size_sel;
    logic [CNT_W-1:0] lane_cnt;
    logic             load;
    logic [IN_W-1:0]  word_q;

    assign size_sel = size_half ? LANE_HALF : LANE_BYTE;

    wdc_order_latch u_order (
        .clk     (clk),
        .rst_n   (rst_n),
        .cfg_big (cfg_big_endian),
        .order_o (order_q)
    );

    wdc_lane_ctrl #(
        .BYTE_LANES (BYTE_LANES),
        .HALF_LANES (HALF_LANES),
        .CNT_W      (CNT_W)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .size_i     (size_sel),
        .in_valid   (in_valid),
        .in_ready   (in_ready),
        .out_valid  (out_valid),
        .out_ready  (out_ready),
        .lane_cnt_o (lane_cnt),
        .load_o     (load)
    );

    // Capture the accepted long-word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= '0;
        end else if (load) begin
            word_q <= in_data;
        end
    end

    wdc_lane_select #(
        .IN_W   (IN_W),
        .OUT_W  (OUT_W),
        .BYTE_W (BYTE_W),
        .CNT_W  (CNT_W)
    ) u_sel (
        .word_i     (word_q),
        .order_i    (order_q),
        .size_i     (size_sel),
        .lane_cnt_i (lane_cnt),
        .data_o     (out_data)
    );

endmodule

// File: rtl/wdc_checker.sv
// Module: wdc_checker
// Protocol and state checks for endian_width_down, attached by bind.
// Assumes: clk/rst_n are the same as the top's.
module wdc_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        size_half,
    input logic        in_valid,
    input logic        in_ready,
    input logic [15:0] out_data,
    input logic        out_valid,
    input logic        out_ready,
    input logic        order_bit
);

    // R9: an edge in reset leaves the output idle
    p_reset_idle_r9: assert property (@(posedge clk)
        !rst_n |=> !out_valid);

    // R6: with nothing held the block must take input
    p_ready_when_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> in_ready);

    // R6: ready with a held word only while that word is leaving
    p_ready_needs_take_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !in_ready);

    // R10: an accepted word shows up on the next cycle
    p_accept_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> out_valid);

    // R8: a stalled lane holds still
    p_hold_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    // R4: byte lanes leave the upper half clear
    p_byte_upper_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !size_half) |-> (out_data[15:8] == 8'h00));

    // R3: the order does not move outside reset
    p_order_fixed_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(order_bit));

endmodule

bind endian_width_down wdc_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .size_half (size_half),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_data  (out_data),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .order_bit (order_q)
);

// File: tb/endian_width_down_test.sv
module endian_width_down_test;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    typedef struct packed {
        logic        big;
        logic        half;
        logic [31:0] data;
        logic [63:0] lanes;   // lane k expected at [16*k +: 16]
    } vec_t;

    localparam vec_t TBL [6] = '{
        '{1'b0, 1'b0, 32'hA1B2C3D4, 64'h00A1_00B2_00C3_00D4},
        '{1'b0, 1'b1, 32'hA1B2C3D4, 64'h0000_0000_A1B2_C3D4},
        '{1'b0, 1'b0, 32'h0F00FF01, 64'h000F_0000_00FF_0001},
        '{1'b1, 1'b0, 32'hA1B2C3D4, 64'h00D4_00C3_00B2_00A1},
        '{1'b1, 1'b1, 32'hA1B2C3D4, 64'h0000_0000_C3D4_A1B2},
        '{1'b1, 1'b1, 32'h80000001, 64'h0000_0000_0001_8000}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_big_endian = 1'b0;
    logic        size_half = 1'b0;
    logic [31:0] in_data = '0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [15:0] out_data;
    logic        out_valid;
    logic        out_ready = 1'b0;

    int n_checks = 0;
    int n_fail   = 0;
    logic cur_big = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    endian_width_down uut (
        .clk            (clk),
        .rst_n          (rst_n),
        .cfg_big_endian (cfg_big_endian),
        .size_half      (size_half),
        .in_data        (in_data),
        .in_valid       (in_valid),
        .in_ready       (in_ready),
        .out_data       (out_data),
        .out_valid      (out_valid),
        .out_ready      (out_ready)
    );

    task automatic check(input bit ok, input string req,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Reset with the given order, then flip the config input (R3)
    task automatic do_reset(input logic big);
        @(negedge clk);
        rst_n = 1'b0; cfg_big_endian = big;
        in_valid = 1'b0; out_ready = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1; cfg_big_endian = ~big;
        cur_big = big;
    endtask

    // Offer a word at a negedge and return at the negedge after acceptance
    task automatic push(input logic [31:0] d);
        in_data = d; in_valid = 1'b1;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // Take one lane, checking the data and in_ready
    task automatic pop(input logic [15:0] exp, input bit last, input string req);
        out_ready = 1'b1;
        #1;
        check(out_valid === 1'b1, req, {31'd0, out_valid}, 32'd1);
        check(out_data === exp, req, {16'd0, out_data}, {16'd0, exp});
        check(in_ready === last, "R6", {31'd0, in_ready}, {31'd0, last});
        @(negedge clk);
        out_ready = 1'b0;
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        do_reset(1'b0);
        // R9: idle after reset
        check(out_valid === 1'b0, "R9", {31'd0, out_valid}, 32'd0);
        check(in_ready === 1'b1, "R9", {31'd0, in_ready}, 32'd1);

        // Vector table: R1/R2 order, R4/R5 lane counts, R10 latency
        foreach (TBL[i]) begin
            if (TBL[i].big !== cur_big) do_reset(TBL[i].big);
            size_half = TBL[i].half;
            @(negedge clk);
            push(TBL[i].data);
            check(out_valid === 1'b1, "R10", {31'd0, out_valid}, 32'd1);
            for (int k = 0; k < (TBL[i].half ? 2 : 4); k++) begin
                pop(TBL[i].lanes[16*k +: 16], k == (TBL[i].half ? 1 : 3),
                    TBL[i].big ? (TBL[i].half ? "R1 R5" : "R1 R4")
                               : (TBL[i].half ? "R2 R5" : "R2 R4"));
            end
            check(out_valid === 1'b0, TBL[i].half ? "R5" : "R4",
                  {31'd0, out_valid}, 32'd0);
        end

        // R8: stall on first lane, big-endian byte mode
        do_reset(1'b1);
        size_half = 1'b0;
        @(negedge clk);
        push(32'h12345678);
        for (int s = 0; s < 3; s++) begin
            check(out_data === 16'h0012, "R8", {16'd0, out_data}, 32'h12);
            check(in_ready === 1'b0, "R6", {31'd0, in_ready}, 32'd0);
            @(negedge clk);
        end
        pop(16'h0012, 1'b0, "R8");
        pop(16'h0034, 1'b0, "R1");
        pop(16'h0056, 1'b0, "R1");
        pop(16'h0078, 1'b1, "R1");

        // R7: back-to-back at last lane, little-endian half-word mode
        do_reset(1'b0);
        size_half = 1'b1;
        @(negedge clk);
        push(32'hAAAA5555);
        pop(16'h5555, 1'b0, "R2");
        out_ready = 1'b1; in_valid = 1'b1; in_data = 32'h01234567;
        #1;
        check(out_data === 16'hAAAA, "R7", {16'd0, out_data}, 32'hAAAA);
        check(in_ready === 1'b1, "R7", {31'd0, in_ready}, 32'd1);
        @(negedge clk);
        in_valid = 1'b0;
        check(out_valid === 1'b1, "R7", {31'd0, out_valid}, 32'd1);
        check(out_data === 16'h4567, "R7", {16'd0, out_data}, 32'h4567);
        pop(16'h4567, 1'b0, "R7");
        pop(16'h0123, 1'b1, "R7");

        // R9: reset mid-word clears the lane position
        do_reset(1'b1);
        size_half = 1'b0;
        @(negedge clk);
        push(32'hCAFEF00D);
        pop(16'h00CA, 1'b0, "R1");
        do_reset(1'b1);
        check(out_valid === 1'b0, "R9", {31'd0, out_valid}, 32'd0);
        @(negedge clk);
        push(32'h01020304);
        pop(16'h0001, 1'b0, "R9 R3");
        pop(16'h0002, 1'b0, "R3");
        pop(16'h0003, 1'b0, "R3");
        pop(16'h0004, 1'b1, "R3");

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule